// File: doc/BRIEF.md
# Reset-Synchronized Three-Phase PWM Generator

This block produces three complementary PWM phase pairs from one up-counter. The counter advances on each enabled clock while the block is running. When it reaches the value of the period register it returns to zero, and that return marks the start of every PWM cycle. Each phase has its own compare register. A phase becomes active on the tick after the counter matches its compare value and goes inactive again at the next counter clear. The negative pin of a phase is always the complement of its positive pin. Polarity inversion, per-pin output enables and a square-wave output that flips once per PWM cycle are applied to these signals.

Software programs the block through a single write port with an address and a data word. Two states control the counter: ST_STOPPED and ST_RUNNING. A control-register write with the start bit set takes the block from ST_STOPPED to ST_RUNNING. A control-register write with the start bit clear takes it back. The PWM mode enable and the two buffer-mode selects are accepted only in ST_STOPPED. In buffered mode, writes made while running are held in a shadow register and take effect only at the next counter clear, so a PWM cycle is never altered partway through.

Top module: `pwm3_reset_sync_pwm`

## Requirements
- R1: While running, the counter advances by one on each cycle with `cnt_en` high. On a tick where the counter equals the active period P, the counter returns to 0, so one PWM cycle lasts P+1 ticks.
- R2: The internal active state of phase i goes high on the tick after the counter equals compare i, and goes low on the tick after a counter clear. With compare C < P, the phase is active for P−C ticks of every cycle. The negative pin carries the complement of the active state.
- R3: A compare value larger than the period never matches, so that phase stays inactive: its positive pin is inactive and its negative pin is active.
- R4: A compare value equal to the period makes the phase state invert at every counter clear.
- R5: Writing 1 to control bit 0 (address 4) leaves ST_STOPPED, and writing 0 returns to it. The counter holds its value in ST_STOPPED. It can be loaded through address 6 only in ST_STOPPED; such writes are ignored in ST_RUNNING.
- R6: Control bit 1 (PWM mode enable), bit 5 and bit 6 take a written value only in ST_STOPPED; in ST_RUNNING these bits keep their previous value. While the mode enable is 0, all six PWM pins are at their inactive level.
- R7: Control bit 2 inverts all positive pins and control bit 3 inverts all negative pins. Each pin equals its active state XOR its inversion bit.
- R8: Address 5 bits 0–2 enable the positive pins of phases 0–2, and bits 3–5 enable the negative pins. A disabled pin holds its inactive level, which equals its inversion bit.
- R9: Period (address 0) uses buffering when control bit 5 is set, and compare 0 (address 1) uses buffering when control bit 6 is set. In buffered mode, a write in ST_RUNNING goes only to the shadow register, and the shadow value is copied to the active register at the next counter clear. In ST_STOPPED, or without buffering, a write updates the active register at once. Compares 1 and 2 (addresses 2 and 3) are never buffered.
- R10: When control bit 4 is set, `period_tog` inverts at every counter clear. While bit 4 is clear, `period_tog` is forced to 0.
- R11: After reset, every register is 0, the block is in ST_STOPPED and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Count enable; one tick per cycle while high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (3) | Register address |
| wr_data | input | W (16) | Register write data |
| pwm_p | output | NPH (3) | Positive-phase PWM pins |
| pwm_n | output | NPH (3) | Negative-phase PWM pins |
| period_tog | output | 1 | Square wave that inverts once per PWM cycle |

## Verification
A wrong counter or a wrong copy of the period shows at the next clear as a wrong cycle length. This appears on `period_tog` and on every phase pin within one PWM cycle. A wrong phase state or a wrong shadow transfer changes a pin's duty or transition tick within the same cycle, or at the first clear after the faulty write. A mode field wrongly accepted while running, or a counter load wrongly accepted while running, changes the pins on the next tick. The bench therefore compares all seven outputs every cycle against a reference model. It also counts high samples over whole-cycle windows.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

    typedef enum logic [0:0] {
        ST_STOPPED = 1'b0,
        ST_RUNNING = 1'b1
    } run_state_e;

    // control register bit positions
    localparam int CB_START = 0;
    localparam int CB_MODE  = 1;
    localparam int CB_INVP  = 2;
    localparam int CB_INVN  = 3;
    localparam int CB_TOG   = 4;
    localparam int CB_BUFP  = 5;
    localparam int CB_BUFC  = 6;

endpackage

// File: rtl/pwm3_shadow_reg.sv
module pwm3_shadow_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wd,
    input  logic         buf_en,
    input  logic         running,
    input  logic         wrap,
    output logic [W-1:0] act,
    output logic [W-1:0] shd
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act <= '0;
            shd <= '0;
        end else if (wr) begin
            shd <= wd;
            if (!(buf_en && running)) begin
                act <= wd;
            end else if (wrap) begin
                act <= shd;
            end
        end else if (wrap && buf_en) begin
            act <= shd;
        end
    end

    // R9: buffered write while running leaves the active value alone until a clear
    a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && buf_en && running && !wrap) |=> (act == $past(act)));

    // R9: at a clear in buffered mode the active value takes the old shadow
    a_r9_copy_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && buf_en) |=> (act == $past(shd)));

endmodule

// File: rtl/pwm3_timebase.sv
module pwm3_timebase
    import pwm3_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         ctrl_wr,
    input  logic         start_bit,
    input  logic         cnt_wr,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] period,
    input  logic         tog_en,
    output logic         running,
    output logic [W-1:0] count,
    output logic         tick,
    output logic         wrap,
    output logic         tog
);

    run_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: if (ctrl_wr && start_bit)  state_d = ST_RUNNING;
            ST_RUNNING: if (ctrl_wr && !start_bit) state_d = ST_STOPPED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    always_comb begin
        running = (state_q == ST_RUNNING);
        tick    = running && cnt_en;
        wrap    = tick && (count == period);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (tick) begin
            count <= wrap ? '0 : count + 1'b1;
        end else if (!running && cnt_wr) begin
            count <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tog <= 1'b0;
        else if (!tog_en) tog <= 1'b0;
        else if (wrap)    tog <= ~tog;
    end

    // R1: a tick on the period value brings the counter back to zero
    a_r1_clear_on_period: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count == period) |=> (count == '0));

    // R5: the counter holds while stopped unless loaded
    a_r5_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cnt_wr) |=> $stable(count));

    // R5: a load while running without a tick leaves the counter unchanged
    a_r5_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cnt_wr && !cnt_en) |=> $stable(count));

    // R10: toggle output cleared while disabled
    a_r10_tog_off: assert property (@(posedge clk) disable iff (!rst_n)
        !tog_en |=> !tog);

endmodule

// File: rtl/pwm3_phase.sv
module pwm3_phase #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wrap,
    input  logic [W-1:0] count,
    input  logic [W-1:0] cmp,
    output logic         raw
);

    logic match;

    always_comb match = tick && (count == cmp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw <= 1'b0;
        end else if (match && wrap) begin
            raw <= ~raw;
        end else if (wrap) begin
            raw <= 1'b0;
        end else if (match) begin
            raw <= 1'b1;
        end
    end

    // R2: a compare match inside the cycle makes the phase active
    a_r2_set_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count == cmp && !wrap) |=> raw);

    // R2: a clear without a match makes the phase inactive
    a_r2_clear_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && count != cmp) |=> !raw);

    // R4: compare equal to period inverts the phase at every clear
    a_r4_full_duty_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && count == cmp) |=> (raw != $past(raw)));

endmodule

// File: rtl/pwm3_regfile.sv
module pwm3_regfile
    import pwm3_pkg::*;
#(
    parameter int W   = 16,
    parameter int NPH = 3,
    parameter int AW  = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [W-1:0]           wr_data,
    input  logic                   running,
    input  logic                   wrap,
    output logic [W-1:0]           per_act,
    output logic [NPH-1:0][W-1:0]  cmp_act,
    output logic                   mode,
    output logic                   inv_p,
    output logic                   inv_n,
    output logic                   tog_en,
    output logic                   ctrl_wr,
    output logic                   start_bit,
    output logic                   cnt_wr,
    output logic [2*NPH-1:0]       oe
);

    localparam int A_PER  = 0;
    localparam int A_CMP0 = 1;
    localparam int A_CTRL = NPH + 1;
    localparam int A_OE   = NPH + 2;
    localparam int A_CNT  = NPH + 3;

    logic buf_p, buf_c;
    logic per_wr, oe_wr;
    logic [W-1:0] per_shd;

    always_comb begin
        per_wr    = wr_en && (wr_addr == AW'(A_PER));
        ctrl_wr   = wr_en && (wr_addr == AW'(A_CTRL));
        oe_wr     = wr_en && (wr_addr == AW'(A_OE));
        cnt_wr    = wr_en && (wr_addr == AW'(A_CNT));
        start_bit = wr_data[CB_START];
    end

    pwm3_shadow_reg #(.W(W)) u_per (
        .clk(clk), .rst_n(rst_n), .wr(per_wr), .wd(wr_data),
        .buf_en(buf_p), .running(running), .wrap(wrap),
        .act(per_act), .shd(per_shd)
    );

    for (genvar g = 0; g < NPH; g++) begin : g_cmp
        logic cmp_wr;
        always_comb cmp_wr = wr_en && (wr_addr == AW'(A_CMP0 + g));
        if (g == 0) begin : g_buffered
            logic [W-1:0] cmp_shd;
            pwm3_shadow_reg #(.W(W)) u_cmp (
                .clk(clk), .rst_n(rst_n), .wr(cmp_wr), .wd(wr_data),
                .buf_en(buf_c), .running(running), .wrap(wrap),
                .act(cmp_act[g]), .shd(cmp_shd)
            );
        end else begin : g_direct
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      cmp_act[g] <= '0;
                else if (cmp_wr) cmp_act[g] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode   <= 1'b0;
            inv_p  <= 1'b0;
            inv_n  <= 1'b0;
            tog_en <= 1'b0;
            buf_p  <= 1'b0;
            buf_c  <= 1'b0;
        end else if (ctrl_wr) begin
            inv_p  <= wr_data[CB_INVP];
            inv_n  <= wr_data[CB_INVN];
            tog_en <= wr_data[CB_TOG];
            if (!running) begin
                mode  <= wr_data[CB_MODE];
                buf_p <= wr_data[CB_BUFP];
                buf_c <= wr_data[CB_BUFC];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     oe <= '0;
        else if (oe_wr) oe <= wr_data[2*NPH-1:0];
    end

    // R6: mode fields are locked while running
    a_r6_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (running && ctrl_wr) |=> (mode == $past(mode) && buf_p == $past(buf_p)
                                  && buf_c == $past(buf_c)));

endmodule

// File: rtl/pwm3_reset_sync_pwm.sv
module pwm3_reset_sync_pwm
    import pwm3_pkg::*;
#(
    parameter  int W   = 16,
    parameter  int NPH = 3,
    localparam int AW  = $clog2(NPH + 4)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cnt_en,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [W-1:0]   wr_data,
    output logic [NPH-1:0] pwm_p,
    output logic [NPH-1:0] pwm_n,
    output logic           period_tog
);

    logic                  running, tick, wrap, tog;
    logic [W-1:0]          count, per_act;
    logic [NPH-1:0][W-1:0] cmp_act;
    logic                  mode, inv_p, inv_n, tog_en;
    logic                  ctrl_wr, start_bit, cnt_wr;
    logic [2*NPH-1:0]      oe;
    logic [NPH-1:0]        raw;

    pwm3_regfile #(.W(W), .NPH(NPH), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .running(running), .wrap(wrap),
        .per_act(per_act), .cmp_act(cmp_act), .mode(mode),
        .inv_p(inv_p), .inv_n(inv_n), .tog_en(tog_en),
        .ctrl_wr(ctrl_wr), .start_bit(start_bit), .cnt_wr(cnt_wr), .oe(oe)
    );

    pwm3_timebase #(.W(W)) u_tb (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .ctrl_wr(ctrl_wr),
        .start_bit(start_bit), .cnt_wr(cnt_wr), .wr_data(wr_data),
        .period(per_act), .tog_en(tog_en), .running(running),
        .count(count), .tick(tick), .wrap(wrap), .tog(tog)
    );

    for (genvar i = 0; i < NPH; i++) begin : g_phase
        pwm3_phase #(.W(W)) u_ph (
            .clk(clk), .rst_n(rst_n), .tick(tick), .wrap(wrap),
            .count(count), .cmp(cmp_act[i]), .raw(raw[i])
        );
    end

    always_comb begin
        for (int i = 0; i < NPH; i++) begin
            pwm_p[i] = (mode & oe[i]       &  raw[i]) ^ inv_p;
            pwm_n[i] = (mode & oe[NPH + i] & ~raw[i]) ^ inv_n;
        end
        period_tog = tog;
    end

    // R6: mode off drives every pin to its inactive level
    a_r6_mode_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !mode |-> (pwm_p == {NPH{inv_p}} && pwm_n == {NPH{inv_n}}));

    for (genvar i = 0; i < NPH; i++) begin : g_chk
        // R2: enabled pin pair is complementary after polarity is removed
        a_r2_complement: assert property (@(posedge clk) disable iff (!rst_n)
            (mode && oe[i] && oe[NPH + i]) |-> ((pwm_p[i] ^ inv_p) != (pwm_n[i] ^ inv_n)));
    end

endmodule

// File: tb/sim_pwm3_reset_sync_pwm.sv
`timescale 1ns/1ps
module sim_pwm3_reset_sync_pwm;

    localparam int W = 16;
    localparam int NPH = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnt_en = 1'b0;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [NPH-1:0] pwm_p, pwm_n;
    logic period_tog;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string tag = "R11";

    always #2.5 clk = ~clk;

    pwm3_reset_sync_pwm #(.W(W), .NPH(NPH)) u0 (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_p(pwm_p), .pwm_n(pwm_n),
        .period_tog(period_tog)
    );

    // reference model state
    bit m_run, m_mode, m_invp, m_invn, m_togen, m_bufp, m_bufc, m_tog;
    logic [W-1:0] m_cnt, m_per, m_pers, m_cmp0s;
    logic [W-1:0] m_cmp [NPH];
    logic [5:0] m_oe;
    bit m_ph [NPH];

    task automatic model_reset();
        m_run = 0; m_mode = 0; m_invp = 0; m_invn = 0; m_togen = 0;
        m_bufp = 0; m_bufc = 0; m_tog = 0; m_cnt = 0; m_per = 0;
        m_pers = 0; m_cmp0s = 0; m_oe = 0;
        for (int i = 0; i < NPH; i++) begin m_cmp[i] = 0; m_ph[i] = 0; end
    endtask

    function automatic logic [6:0] exp_out();
        logic [6:0] v;
        for (int i = 0; i < NPH; i++) begin
            v[i]       = (m_mode && m_oe[i]     &&  m_ph[i]) ^ m_invp;
            v[NPH + i] = (m_mode && m_oe[NPH+i] && !m_ph[i]) ^ m_invn;
        end
        v[6] = m_tog;
        return v;
    endfunction

    task automatic model_step(input bit we, input logic [2:0] a, input logic [W-1:0] d,
                              input bit ce);
        bit tk, clr;
        bit nph [NPH];
        logic [W-1:0] ncnt, nper, npers, ncmp0, ncmp0s;
        tk  = m_run && ce;
        clr = tk && (m_cnt == m_per);
        ncnt = m_cnt;
        if (tk) ncnt = clr ? '0 : m_cnt + 1'b1;
        else if (!m_run && we && a == 3'd6) ncnt = d;
        for (int i = 0; i < NPH; i++) begin
            bit hit;
            hit = tk && (m_cnt == m_cmp[i]);
            nph[i] = m_ph[i];
            if (hit && clr) nph[i] = !m_ph[i];
            else if (clr)   nph[i] = 0;
            else if (hit)   nph[i] = 1;
        end
        nper = m_per; npers = m_pers;
        if (clr && m_bufp) nper = m_pers;
        if (we && a == 3'd0) begin
            npers = d;
            if (!(m_bufp && m_run)) nper = d;
        end
        ncmp0 = m_cmp[0]; ncmp0s = m_cmp0s;
        if (clr && m_bufc) ncmp0 = m_cmp0s;
        if (we && a == 3'd1) begin
            ncmp0s = d;
            if (!(m_bufc && m_run)) ncmp0 = d;
        end
        if (!m_togen) m_tog = 0;
        else if (clr) m_tog = !m_tog;
        if (we && a == 3'd2) m_cmp[1] = d;
        if (we && a == 3'd3) m_cmp[2] = d;
        if (we && a == 3'd5) m_oe = d[5:0];
        if (we && a == 3'd4) begin
            m_invp = d[2]; m_invn = d[3]; m_togen = d[4];
            if (!m_run) begin m_mode = d[1]; m_bufp = d[5]; m_bufc = d[6]; end
            m_run = d[0];
        end
        m_cnt = ncnt; m_per = nper; m_pers = npers;
        m_cmp[0] = ncmp0; m_cmp0s = ncmp0s;
        for (int i = 0; i < NPH; i++) m_ph[i] = nph[i];
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input bit we, input logic [2:0] a, input logic [W-1:0] d, input bit ce);
        @(negedge clk);
        chk(tag, {25'd0, period_tog, pwm_n, pwm_p}, {25'd0, exp_out()});
        wr_en = we; wr_addr = a; wr_data = d; cnt_en = ce;
        model_step(we, a, d, ce);
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        step(1, a, d, 1);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(0, 3'd0, '0, 1);
    endtask

    // count high samples of one output bit over a window of n cycles
    task automatic window(input int sel, input int n, output int hi);
        hi = 0;
        for (int k = 0; k < n; k++) begin
            step(0, 3'd0, '0, 1);
            if ({period_tog, pwm_n, pwm_p} & (7'd1 << sel)) hi++;
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int hi;
        logic [6:0] held;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        chk("R11", {25'd0, period_tog, pwm_n, pwm_p}, 32'd0);

        tag = "R2";
        wr(3'd0, 16'd9); wr(3'd1, 16'd3); wr(3'd2, 16'd5); wr(3'd3, 16'd9);
        wr(3'd5, 16'h3F); wr(3'd6, 16'd0);
        wr(3'd4, 16'h13);
        idle(25);
        window(6, 40, hi); chk("R1 cycle length via toggle", hi, 20);
        window(0, 40, hi); chk("R2 phase0 duty", hi, 24);
        window(3, 40, hi); chk("R2 phase0 negative duty", hi, 16);
        tag = "R4";
        window(2, 40, hi); chk("R4 full duty toggles", hi, 20);

        tag = "R3";
        wr(3'd2, 16'd20);
        idle(25);
        window(1, 40, hi); chk("R3 positive never active", hi, 0);
        window(4, 40, hi); chk("R3 negative always active", hi, 40);

        tag = "R6";
        wr(3'd4, 16'h11);
        idle(15);
        window(0, 40, hi); chk("R6 mode write ignored while running", hi, 24);

        tag = "R5";
        wr(3'd6, 16'd2);
        idle(15);
        window(0, 40, hi); chk("R5 counter load ignored while running", hi, 24);
        wr(3'd4, 16'h12);
        idle(2);
        held = {period_tog, pwm_n, pwm_p};
        idle(20);
        chk("R5 outputs hold while stopped", {period_tog, pwm_n, pwm_p}, held);

        tag = "R9";
        wr(3'd4, 16'h72);
        wr(3'd4, 16'h73);
        idle(12);
        wr(3'd0, 16'd4); wr(3'd1, 16'd1);
        idle(30);
        window(6, 40, hi); chk("R9 new period after clear", hi, 20);
        window(0, 40, hi); chk("R9 new compare after clear", hi, 24);

        tag = "R7";
        wr(3'd4, 16'h7F);
        idle(20);
        window(0, 40, hi); chk("R7 inverted positive", hi, 16);
        tag = "R8";
        wr(3'd5, 16'h2A);
        idle(5);
        window(0, 20, hi); chk("R8 disabled pin at inactive level", hi, 20);

        tag = "R10";
        wr(3'd4, 16'h6F);
        idle(3);
        window(6, 20, hi); chk("R10 toggle cleared when disabled", hi, 0);

        tag = "R6";
        wr(3'd4, 16'h00); wr(3'd4, 16'h10); wr(3'd4, 16'h11);
        idle(15);
        chk("R6 mode off pins inactive", {pwm_n, pwm_p}, 32'd0);

        tag = "R1";
        for (int k = 0; k < 4000; k++) begin
            int r;
            r = $urandom % 100;
            if (r < 3)       step(1, 3'd0, 16'($urandom % 13 + 2), $urandom % 4 != 0);
            else if (r < 7)  step(1, 3'(1 + $urandom % 3), 16'($urandom % 16), $urandom % 4 != 0);
            else if (r < 9)  step(1, 3'd4, {9'd0, 7'($urandom) | 7'((($urandom % 10) != 0) ? 1 : 0)},
                                  $urandom % 4 != 0);
            else if (r < 11) step(1, 3'd5, 16'($urandom % 64), $urandom % 4 != 0);
            else if (r < 12) step(1, 3'd6, 16'($urandom % 12), $urandom % 4 != 0);
            else             step(0, 3'd0, '0, $urandom % 4 != 0);
        end
        idle(2);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule